// File: doc/BRIEF.md
# Synchronized Double-Buffered Control Register Update

This block holds two copies of a small bank of control registers. A plain write port fills the staging copy at any time. The active copy feeds the rest of the chip, and it changes only when an update request is seen. This lets software load several fields, such as a tuning word, a phase offset and an amplitude, and make them all take effect together. The transfer always lands a fixed number of system clocks after a slow synchronization clock edge, so new values take effect without breaking output phase continuity.

The synchronization clock is the system clock divided by four. It is driven out so that external logic can time itself from it. The update request is sampled only when this clock rises. A rising edge between two samples gives exactly one transfer, however long the request then stays high.

The block also scales a sample stream. When the active control register selects external shaped keying, each sample is multiplied by the active amplitude register. Otherwise the samples pass through unchanged.

Top module: `regbank_sync_update`

## Requirements
- R1: After reset is released, count system rising edges n = 1, 2, 3, .... After edge n, `sync_clk_o` is high when n mod 4 is 2 or 3 and low when it is 0 or 1. This gives a 50% duty cycle at one quarter of the system rate.
- R2: While `sync_off` is 1, `sync_clk_o` is 0. The divider keeps counting, so the R1 phase continues unchanged when `sync_off` returns to 0. Update sampling carries on while the output is held low.
- R3: A write (`wr_en`=1 stores `wr_data` into staging register `wr_addr` at a system edge) never changes `act_regs`. The active bank changes only through a transfer.
- R4: `upd_in` is sampled at the system edges where n mod 4 is 2, which are the rising edges of the synchronization clock. A transfer happens when a sample is 1 and the sample before it was 0. At the next system edge, n+1, all staging registers are copied into `act_regs`. Register k occupies bits [k*DW +: DW].
- R5: Holding `upd_in` high across several samples gives only one transfer. Staging writes made while it stays high do not reach the active bank.
- R6: A pulse on `upd_in` that rises and falls between two sampling edges is never seen and causes no transfer.
- R7: While reset is asserted, `act_regs` is all zero, `dout` is zero and `sync_clk_o` is low.
- R8: Active register 0 selects keying mode when its bit 25 is 1 and its bit 24 is 0. In keying mode, one system clock after `din` is presented, `dout` equals floor(`din` × A / 2^SW). Here A is bits [SW-1:0] of active register 1, and both values are unsigned.
- R9: When keying mode is not selected (bits 25:24 of active register 0 are 00, 01 or 11), `dout` equals `din` one system clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_off | input | 1 | Holds the synchronization clock output low |
| upd_in | input | 1 | Update request, sampled on synchronization clock rising edges |
| wr_en | input | 1 | Staging register write strobe |
| wr_addr | input | $clog2(NREG) | Staging register index |
| wr_data | input | DW | Staging write data |
| din | input | SW | Sample input, unsigned |
| sync_clk_o | output | 1 | System clock divided by four |
| act_regs | output | NREG*DW | Active register bank, flattened |
| dout | output | SW | Scaled or passed-through sample, registered |

## Verification
The hard part is placing an update edge at a chosen position relative to the divider phase. Only one system edge in four samples the request, so a pulse can be missed entirely or stretched across several samples. The bench counts system edges from reset release. It raises or drops the request at each of the four phases, and it fits short pulses between two sampling edges. It also holds the request high while new staging writes are made, and it makes one request while the clock output is disabled. For each request it computes the exact edge at which the active bank must change.

// File: rtl/rbu_pkg.sv
package rbu_pkg;
  // register roles inside the bank; the keying decode depends on them
  localparam int CTRL_IDX     = 0;
  localparam int AMP_IDX      = 1;
  localparam int KEY_EXT_BIT  = 25;
  localparam int KEY_AUTO_BIT = 24;

  // divide-by-four phase: the update is sampled on the step PH_TICK -> PH_HI0
  typedef enum logic [1:0] {
    PH_LO0 = 2'd0,
    PH_TICK = 2'd1,
    PH_HI0 = 2'd2,
    PH_HI1 = 2'd3
  } phase_e;
endpackage

// File: rtl/rbu_sync_div.sv
module rbu_sync_div
  import rbu_pkg::*;
(
  input  logic sys_clk,
  input  logic rst_n,
  input  logic sync_off,
  output logic sync_clk_o,
  output logic sample_tick
);
  phase_e phase;
  logic   sync_raw;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_LO0;
    else        phase <= phase_e'(phase + 2'd1);
  end

  assign sync_raw    = (phase == PH_HI0) || (phase == PH_HI1);
  assign sample_tick = (phase == PH_TICK);
  assign sync_clk_o  = sync_raw & ~sync_off;

  // R1
  sync_rise_after_tick_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    $rose(sync_raw) |-> $past(sample_tick));
  // R4
  tick_single_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick);
endmodule

// File: rtl/rbu_update_edge.sv
module rbu_update_edge (
  input  logic sys_clk,
  input  logic rst_n,
  input  logic sample_tick,
  input  logic upd_in,
  output logic xfer_pulse
);
  logic smp_cur, smp_prev, tick_d;

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_cur  <= 1'b0;
      smp_prev <= 1'b0;
      tick_d   <= 1'b0;
    end else begin
      tick_d <= sample_tick;
      if (sample_tick) begin
        smp_cur  <= upd_in;
        smp_prev <= smp_cur;
      end
    end
  end

  assign xfer_pulse = tick_d & smp_cur & ~smp_prev;

  // R5
  xfer_single_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    xfer_pulse |=> !xfer_pulse);
  // R4
  xfer_cause_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    xfer_pulse |-> $past(upd_in));
endmodule

// File: rtl/rbu_bank.sv
module rbu_bank #(
  parameter int NREG = 4,
  parameter int DW   = 32,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               sys_clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               xfer_pulse,
  output logic [NREG*DW-1:0] act_flat
);
  logic [NREG*DW-1:0] stage_flat;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] stage_q, act_q;

    always_ff @(posedge sys_clk or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else if (wr_en && (wr_addr == AW'(i))) stage_q <= wr_data;
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
      if (!rst_n) act_q <= '0;
      else if (xfer_pulse) act_q <= stage_q;
    end

    assign stage_flat[i*DW +: DW] = stage_q;
    assign act_flat[i*DW +: DW]   = act_q;
  end

  // R3
  hold_without_xfer_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !xfer_pulse |=> $stable(act_flat));
  // R4
  load_on_xfer_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    xfer_pulse |=> act_flat == $past(stage_flat));
endmodule

// File: rtl/rbu_scale.sv
module rbu_scale
  import rbu_pkg::*;
#(
  parameter int DW = 32,
  parameter int SW = 14
) (
  input  logic          sys_clk,
  input  logic          rst_n,
  input  logic [DW-1:0] ctrl_reg,
  input  logic [DW-1:0] amp_reg,
  input  logic [SW-1:0] din,
  output logic          key_mode,
  output logic [SW-1:0] dout
);
  function automatic logic keying_sel(input logic [DW-1:0] c);
    return c[KEY_EXT_BIT] & ~c[KEY_AUTO_BIT];
  endfunction

  function automatic logic [SW-1:0] apply_scale(input logic [SW-1:0] s, input logic [SW-1:0] k);
    logic [2*SW-1:0] p;
    p = {{SW{1'b0}}, s} * {{SW{1'b0}}, k};
    return p[2*SW-1:SW];
  endfunction

  logic [SW-1:0] amp_w;
  assign amp_w    = amp_reg[SW-1:0];
  assign key_mode = keying_sel(ctrl_reg);

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n)        dout <= '0;
    else if (key_mode) dout <= apply_scale(din, amp_w);
    else               dout <= din;
  end

  // R9
  passthru_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !key_mode |=> dout == $past(din));
  // R8
  zero_amp_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (key_mode && amp_w == '0) |=> dout == '0);
endmodule

// File: rtl/regbank_sync_update.sv
module regbank_sync_update
  import rbu_pkg::*;
#(
  parameter int NREG = 4,
  parameter int DW   = 32,
  parameter int SW   = 14,
  localparam int AW  = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               sys_clk,
  input  logic               rst_n,
  input  logic               sync_off,
  input  logic               upd_in,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic [SW-1:0]      din,
  output logic               sync_clk_o,
  output logic [NREG*DW-1:0] act_regs,
  output logic [SW-1:0]      dout
);
  logic sample_tick;
  logic xfer_pulse;
  logic key_mode;

  rbu_sync_div u_div (
    .sys_clk(sys_clk), .rst_n(rst_n), .sync_off(sync_off),
    .sync_clk_o(sync_clk_o), .sample_tick(sample_tick)
  );

  rbu_update_edge u_edge (
    .sys_clk(sys_clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .upd_in(upd_in), .xfer_pulse(xfer_pulse)
  );

  rbu_bank #(.NREG(NREG), .DW(DW)) u_bank (
    .sys_clk(sys_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .xfer_pulse(xfer_pulse), .act_flat(act_regs)
  );

  rbu_scale #(.DW(DW), .SW(SW)) u_scale (
    .sys_clk(sys_clk), .rst_n(rst_n),
    .ctrl_reg(act_regs[CTRL_IDX*DW +: DW]),
    .amp_reg(act_regs[AMP_IDX*DW +: DW]),
    .din(din), .key_mode(key_mode), .dout(dout)
  );

  // R8
  key_follows_bank_chk: assert property (@(posedge sys_clk) disable iff (!rst_n)
    (!xfer_pulse && key_mode) |=> key_mode);
endmodule

// File: tb/regbank_sync_update_test.sv
module regbank_sync_update_test;
  localparam int NREG = 4;
  localparam int DW   = 32;
  localparam int SW   = 14;
  localparam int AW   = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               sync_off = 1'b0;
  logic               upd_in = 1'b0;
  logic               wr_en = 1'b0;
  logic [AW-1:0]      wr_addr = '0;
  logic [DW-1:0]      wr_data = '0;
  logic [SW-1:0]      din = '0;
  logic               sync_clk_o;
  logic [NREG*DW-1:0] act_regs;
  logic [SW-1:0]      dout;

  regbank_sync_update #(.NREG(NREG), .DW(DW), .SW(SW)) uut (
    .sys_clk(clk), .rst_n(rst_n), .sync_off(sync_off), .upd_in(upd_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .din(din),
    .sync_clk_o(sync_clk_o), .act_regs(act_regs), .dout(dout)
  );

  always #10 clk = ~clk;

  typedef struct {
    int                 due;
    logic [NREG*DW-1:0] bank;
  } item_t;

  item_t              sb_q[$];
  int                 n_chk = 0;
  int                 n_fail = 0;
  int                 cyc = 0;
  logic [DW-1:0]      buf_m [NREG];
  logic [NREG*DW-1:0] exp_bank = '0;
  logic [NREG*DW-1:0] bank_rec = '0;
  logic [SW-1:0]      din_rec = '0;
  string              cur_req = "R3";
  bit                 din_run = 1'b0;
  bit                 finished = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input string req, input logic [NREG*DW-1:0] act, input logic [NREG*DW-1:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, expv);
    end
  endtask

  function automatic logic [NREG*DW-1:0] pack_buf();
    logic [NREG*DW-1:0] r;
    for (int i = 0; i < NREG; i++) r[i*DW +: DW] = buf_m[i];
    return r;
  endfunction

  function automatic logic [SW-1:0] model_out(input logic [SW-1:0] s, input logic [NREG*DW-1:0] b);
    longint unsigned a, v;
    if (b[25] == 1'b1 && b[24] == 1'b0) begin
      a = longint'(b[DW +: SW]);
      v = (longint'(s) * a) / (longint'(1) << SW);
      return SW'(v);
    end
    return s;
  endfunction

  // monitor: pops due items and checks every output away from the edge
  always @(negedge clk) begin
    if (!rst_n) begin
      check("R7", {act_regs, dout, sync_clk_o}, '0);
    end else if (!finished) begin
      while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
        exp_bank = sb_q[0].bank;
        check("R4", act_regs, sb_q[0].bank);
        void'(sb_q.pop_front());
      end
      check(cur_req, act_regs, exp_bank);
      begin
        logic es;
        es = !sync_off && ((cyc % 4) == 2 || (cyc % 4) == 3);
        check(sync_off ? "R2" : "R1", NREG*DW'(sync_clk_o), NREG*DW'(es));
      end
      begin
        logic is_key;
        is_key = bank_rec[25] && !bank_rec[24];
        check(is_key ? "R8" : "R9", NREG*DW'(dout), NREG*DW'(model_out(din_rec, bank_rec)));
      end
    end
    din_rec  = din;
    bank_rec = exp_bank;
  end

  // sample stream
  initial begin
    logic [SW-1:0] lf;
    lf = 14'h1ACE;
    forever begin
      @(posedge clk); #2;
      if (din_run) begin
        lf = {lf[SW-2:0], lf[13] ^ lf[12] ^ lf[11] ^ lf[1]};
        din = lf;
      end
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    step();
    wr_en = 1'b0;
    buf_m[a] = d;
  endtask

  function automatic int next_due();
    int n;
    n = cyc + 1;
    while ((n % 4) != 2) n++;
    return n + 1;
  endfunction

  task automatic upd_pulse(input int hold);
    item_t it;
    it.due  = next_due();
    it.bank = pack_buf();
    sb_q.push_back(it);
    upd_in = 1'b1;
    repeat (hold) step();
    upd_in = 1'b0;
    repeat (8) step();
  endtask

  task automatic wait_phase(input int p);
    while ((cyc % 4) != p) step();
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) buf_m[i] = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    din_run = 1'b1;
    repeat (6) step();

    // R3: staging writes alone leave the active bank at zero
    cur_req = "R3";
    wr(2, 32'h1234_5678);
    wr(3, 32'h0BAD_F00D);
    wr(1, 32'h0000_2000);
    repeat (10) step();

    // R4: first transfer
    cur_req = "R4";
    upd_pulse(5);

    // R8: keying mode with half scale; R3: not active before the transfer
    cur_req = "R3";
    wr(0, 32'h0200_0000);
    repeat (6) step();
    cur_req = "R8";
    upd_pulse(6);
    repeat (12) step();

    // R5: request held high, later writes stay staged
    cur_req = "R5";
    begin
      item_t it;
      it.due = next_due();
      it.bank = pack_buf();
      sb_q.push_back(it);
      upd_in = 1'b1;
      repeat (6) step();
      wr(2, 32'hCAFE_0001);
      wr(1, 32'h0000_0123);
      repeat (14) step();
      upd_in = 1'b0;
      repeat (8) step();
    end
    upd_pulse(4);

    // R9: bits 25:24 = 11 and 01 both pass through
    cur_req = "R9";
    wr(0, 32'h0300_0000);
    upd_pulse(4);
    repeat (6) step();
    wr(0, 32'h0100_0000);
    upd_pulse(4);
    repeat (6) step();

    // R8: full-scale and zero amplitude
    cur_req = "R8";
    wr(0, 32'h0200_0000);
    wr(1, 32'h0000_3FFF);
    upd_pulse(4);
    repeat (8) step();
    wr(1, 32'h0000_0000);
    upd_pulse(4);
    repeat (8) step();

    // R6: a pulse fitted between two sampling edges is never seen
    cur_req = "R6";
    wr(3, 32'h7777_0000);
    wait_phase(2);
    upd_in = 1'b1;
    step();
    step();
    upd_in = 1'b0;
    repeat (12) step();

    // R2: output held low, divider phase kept, sampling continues
    cur_req = "R2";
    sync_off = 1'b1;
    upd_pulse(4);
    repeat (5) step();
    sync_off = 1'b0;
    repeat (9) step();

    // R4: requests raised at each of the four divider phases
    cur_req = "R4";
    for (int p = 0; p < 4; p++) begin
      wr(2, 32'h5000_0000 + DW'(p));
      wait_phase(p);
      upd_pulse(4);
    end
    repeat (8) step();

    if (sb_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R4 pending transfers actual=%0d expected=0", sb_q.size());
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    finished = 1'b1;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule